// File: doc/BRIEF.md
# Ethernet receive acceptance filter

This block makes the keep-or-drop decision for each received Ethernet frame. An upstream parser presents the destination address, the EtherType, the 16-bit tag control word and the frame length, with a one-cycle `frm_valid` strobe. The filter combines the live control bits, a bank of sixteen exact-match address slots, a 4096-bit multicast hash bitmap and a 4096-bit VLAN membership bitmap. It returns a single registered accept or reject pulse two clock edges after the strobe. Frames can be presented on every cycle.

The slots and both bitmaps are loaded through a simple write port. The bitmaps are held in synchronous-read memories that can be inferred as block RAM. When a frame is too long and bad frames are not being kept, a saturating counter records it.

Address byte `i` of the destination sits at `frm_dst[8*i+7 : 8*i]`. Byte 0 is the first byte on the wire.

Top module: `rx_accept_filter`

## Requirements
- R1: A frame is rejected when any of `link_up`, `rx_en` or `bus_master` is low. Such a frame never advances the oversize counter.
- R2: When `bcast_accept` is set, a destination of all ones is accepted. When `bcast_accept` is clear, such a frame is not accepted through `mcast_promisc`.
- R3: A destination with `frm_dst[0]` set that is not all ones is accepted when `mcast_promisc` is set.
- R4: A destination with `frm_dst[0]` clear is accepted when `ucast_promisc` is set. That bit never accepts a multicast destination.
- R5: Slot `s` is written through `cfg_sel`=2 (`cfg_wdata` = bytes 3..0, byte 0 in bits 7:0) and `cfg_sel`=3 (bits 15:0 = bytes 5..4, bit 31 = valid), with `cfg_addr[3:0]`=`s`. A valid slot whose 48 bits equal the destination accepts the frame. A slot whose valid bit is clear never matches.
- R6: The hash index is the low 12 bits of `frm_dst[47:32]` shifted right by 4, 3, 2 or 0 for `hash_offset` = 0, 1, 2, 3. Index bits 11:5 pick hash word (`cfg_sel`=0), bits 4:0 pick the bit, and a set bit accepts the frame.
- R7: A frame is tagged when `frm_etype` equals `vlan_type`. With `vlan_filter_en` set, a tagged frame is rejected when the VLAN bitmap (`cfg_sel`=1) bit at word `frm_tci[11:5]`, bit `frm_tci[4:0]` is zero. Untagged frames and frames seen with the filter off pass this check.
- R8: A frame is oversized when `frm_len` exceeds 16380, or exceeds 1518 with `long_pkt_en` clear. An oversized frame is rejected.
- R9: With `store_bad` set, an oversized frame is not rejected for its length and is judged by the other checks.
- R10: Each oversized frame from a ready port with `store_bad` clear adds one to `ovs_count`, which holds at all ones instead of wrapping.
- R11: `dec_valid` is a one-cycle pulse two rising edges after each `frm_valid` cycle, and is low otherwise. Back-to-back frames give back-to-back pulses in order.
- R12: A table or slot write in the same cycle as a frame strobe does not affect that frame's decision. It applies from the next frame.
- R13: After reset `dec_valid` is 0, `ovs_count` is 0 and every address slot is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link is up |
| rx_en | input | 1 | Receiver enabled |
| bus_master | input | 1 | Host bus mastering permitted |
| bcast_accept | input | 1 | Accept broadcast destinations |
| mcast_promisc | input | 1 | Accept all multicast destinations |
| ucast_promisc | input | 1 | Accept all unicast destinations |
| vlan_filter_en | input | 1 | Enable VLAN membership check |
| long_pkt_en | input | 1 | Raise length limit to 16380 |
| store_bad | input | 1 | Keep oversized frames |
| hash_offset | input | 2 | Hash index shift select |
| vlan_type | input | 16 | EtherType that marks a tagged frame |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | 0 hash, 1 VLAN, 2 slot low word, 3 slot high word |
| cfg_addr | input | 7 | Word index or slot number |
| cfg_wdata | input | 32 | Write data |
| frm_valid | input | 1 | Frame fields valid this cycle |
| frm_dst | input | 48 | Destination address, byte 0 in bits 7:0 |
| frm_etype | input | 16 | EtherType field |
| frm_tci | input | 16 | Tag control word |
| frm_len | input | 15 | Frame length in bytes |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted, valid with dec_valid |
| ovs_count | output | 16 | Saturating oversize counter |

## Verification
A table write and a frame decision can fall in the same cycle. The bench drives a VLAN bitmap write that would admit a frame in the same cycle as that frame's strobe. It expects the old bitmap to reject the frame, and expects an identical frame on a later cycle to be accepted. A second overlap is a counter update together with a decision. Oversized frames are sent while the counter is at all ones, and the bench checks both the reject pulse and the held count.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int unsigned MAC_W   = 48;
  localparam int unsigned ETYPE_W = 16;

  typedef enum logic [1:0] {
    SEL_HASH    = 2'd0,
    SEL_VLAN    = 2'd1,
    SEL_SLOT_LO = 2'd2,
    SEL_SLOT_HI = 2'd3
  } cfg_sel_e;

  // right shift applied to {byte5, byte4} before taking the hash index
  function automatic int unsigned hash_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4;
      2'd1:    return 3;
      2'd2:    return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rxf_bitmap_ram.sv
module rxf_bitmap_ram #(
  parameter int unsigned WORDS = 128,
  parameter int unsigned WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] wr_addr,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic                     rd_en,
  input  logic [$clog2(WORDS)-1:0] rd_addr,
  output logic [WIDTH-1:0]         rd_data
);

  logic [WIDTH-1:0] mem [WORDS];

  // read-first: a write and a read to one word in one cycle return old data
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/rxf_addr_cam.sv
module rxf_addr_cam #(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned MAC_W = 48
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_lo,
  input  logic                     wr_hi,
  input  logic [$clog2(SLOTS)-1:0] wr_slot,
  input  logic [31:0]              wr_data,
  input  logic [MAC_W-1:0]         key,
  output logic                     hit
);

  localparam int unsigned HI_W = MAC_W - 32;

  logic [SLOTS-1:0] match;
  wire unused_wdata = &{1'b0, wr_data[30:HI_W]};

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [31:0]   lo_q;
    logic [HI_W-1:0] hi_q;
    logic          vld_q;
    wire           sel = (wr_slot == s[$clog2(SLOTS)-1:0]);

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
      end else if (wr_hi && sel) begin
        vld_q <= wr_data[31];
      end
    end

    always_ff @(posedge clk) begin
      if (wr_lo && sel) lo_q <= wr_data;
      if (wr_hi && sel) hi_q <= wr_data[HI_W-1:0];
    end

    assign match[s] = vld_q && ({hi_q, lo_q} == key);
  end

  assign hit = |match;

endmodule

// File: rtl/rxf_sat_counter.sv
module rxf_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && (count != '1)) begin
      count <= count + W'(1);
    end
  end

endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter #(
  parameter int unsigned SLOTS     = 16,
  parameter int unsigned TBL_WORDS = 128,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned LEN_W     = 15,
  parameter int unsigned MAX_STD   = 1518,
  parameter int unsigned MAX_JUMBO = 16380
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     link_up,
  input  logic                     rx_en,
  input  logic                     bus_master,
  input  logic                     bcast_accept,
  input  logic                     mcast_promisc,
  input  logic                     ucast_promisc,
  input  logic                     vlan_filter_en,
  input  logic                     long_pkt_en,
  input  logic                     store_bad,
  input  logic [1:0]               hash_offset,
  input  logic [15:0]              vlan_type,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_sel,
  input  logic [$clog2(TBL_WORDS)-1:0] cfg_addr,
  input  logic [31:0]              cfg_wdata,
  input  logic                     frm_valid,
  input  logic [47:0]              frm_dst,
  input  logic [15:0]              frm_etype,
  input  logic [15:0]              frm_tci,
  input  logic [LEN_W-1:0]         frm_len,
  output logic                     dec_valid,
  output logic                     dec_accept,
  output logic [CNT_W-1:0]         ovs_count
);
  import rxf_pkg::*;

  localparam int unsigned TBL_AW  = $clog2(TBL_WORDS);
  localparam int unsigned BIT_AW  = $clog2(WORD_W);
  localparam int unsigned IDX_W   = TBL_AW + BIT_AW;
  localparam int unsigned SLOT_AW = $clog2(SLOTS);
  localparam logic [LEN_W-1:0] STD_LIM   = LEN_W'(MAX_STD);
  localparam logic [LEN_W-1:0] JUMBO_LIM = LEN_W'(MAX_JUMBO);

  wire unused_tci = &{1'b0, frm_tci[15:IDX_W]};

  // ---------------- table write decode ----------------
  wire hash_we = cfg_we && (cfg_sel == SEL_HASH);
  wire vlan_we = cfg_we && (cfg_sel == SEL_VLAN);
  wire slot_lo = cfg_we && (cfg_sel == SEL_SLOT_LO);
  wire slot_hi = cfg_we && (cfg_sel == SEL_SLOT_HI);

  // ---------------- stage 0: combinational pre-decision ----------------
  logic             port_ready;
  logic             too_long;
  logic             is_bcast;
  logic             is_mcast;
  logic             promisc_hit;
  logic             cam_hit;
  logic             vlan_chk;
  logic [15:0]      hash_src;
  logic [15:0]      hash_shf;
  logic [IDX_W-1:0] hash_idx;

  always_comb begin
    port_ready  = link_up && rx_en && bus_master;
    too_long    = (frm_len > JUMBO_LIM) || ((frm_len > STD_LIM) && !long_pkt_en);
    is_bcast    = &frm_dst;
    is_mcast    = frm_dst[0];
    promisc_hit = (is_bcast && bcast_accept)
                || (is_mcast && !is_bcast && mcast_promisc)
                || (!is_mcast && ucast_promisc);
    vlan_chk    = vlan_filter_en && (frm_etype == vlan_type);
    hash_src    = frm_dst[47:32];
    hash_shf    = hash_src >> hash_shift(hash_offset);
    hash_idx    = hash_shf[IDX_W-1:0];
  end

  rxf_addr_cam #(
    .SLOTS (SLOTS),
    .MAC_W (MAC_W)
  ) u_cam (
    .clk     (clk),
    .rst     (rst),
    .wr_lo   (slot_lo),
    .wr_hi   (slot_hi),
    .wr_slot (cfg_addr[SLOT_AW-1:0]),
    .wr_data (cfg_wdata),
    .key     (frm_dst),
    .hit     (cam_hit)
  );

  logic [WORD_W-1:0] hash_word;
  logic [WORD_W-1:0] vlan_word;

  rxf_bitmap_ram #(
    .WORDS (TBL_WORDS),
    .WIDTH (WORD_W)
  ) u_hash_tbl (
    .clk     (clk),
    .wr_en   (hash_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata[WORD_W-1:0]),
    .rd_en   (frm_valid),
    .rd_addr (hash_idx[IDX_W-1:BIT_AW]),
    .rd_data (hash_word)
  );

  rxf_bitmap_ram #(
    .WORDS (TBL_WORDS),
    .WIDTH (WORD_W)
  ) u_vlan_tbl (
    .clk     (clk),
    .wr_en   (vlan_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata[WORD_W-1:0]),
    .rd_en   (frm_valid),
    .rd_addr (frm_tci[IDX_W-1:BIT_AW]),
    .rd_data (vlan_word)
  );

  // ---------------- stage 1 registers ----------------
  typedef struct packed {
    logic              gate;      // ready and not dropped for length
    logic              addr_hit;  // promiscuous or exact-match hit
    logic              vlan_chk;
    logic [BIT_AW-1:0] hash_bit;
    logic [BIT_AW-1:0] vlan_bit;
    logic              count_ovs;
  } s1_t;

  logic s1_valid;
  s1_t  s1;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= frm_valid;
  end

  always_ff @(posedge clk) begin
    if (frm_valid) begin
      s1.gate      <= port_ready && !(too_long && !store_bad);
      s1.addr_hit  <= promisc_hit || cam_hit;
      s1.vlan_chk  <= vlan_chk;
      s1.hash_bit  <= hash_idx[BIT_AW-1:0];
      s1.vlan_bit  <= frm_tci[BIT_AW-1:0];
      s1.count_ovs <= port_ready && too_long && !store_bad;
    end
  end

  // ---------------- stage 2: final decision ----------------
  wire hash_ok = hash_word[s1.hash_bit];
  wire vlan_ok = !s1.vlan_chk || vlan_word[s1.vlan_bit];

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= s1_valid;
      dec_accept <= s1_valid && s1.gate && vlan_ok && (s1.addr_hit || hash_ok);
    end
  end

  rxf_sat_counter #(
    .W (CNT_W)
  ) u_ovs_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (s1_valid && s1.count_ovs),
    .count (ovs_count)
  );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int unsigned LEN_W   = 15,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MAX_STD = 1518
) (
  input logic             clk,
  input logic             rst,
  input logic             frm_valid,
  input logic             link_up,
  input logic             rx_en,
  input logic             bus_master,
  input logic             long_pkt_en,
  input logic             store_bad,
  input logic [LEN_W-1:0] frm_len,
  input logic             dec_valid,
  input logic             dec_accept,
  input logic [CNT_W-1:0] ovs_count
);

  localparam logic [LEN_W-1:0] STD_LIM = LEN_W'(MAX_STD);

  assert_not_ready_R1: assert property (@(posedge clk) disable iff (rst)
    frm_valid && !(link_up && rx_en && bus_master) |-> ##2 (dec_valid && !dec_accept));

  assert_long_reject_R8: assert property (@(posedge clk) disable iff (rst)
    frm_valid && (frm_len > STD_LIM) && !long_pkt_en && !store_bad |-> ##2 !dec_accept);

  assert_sat_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (ovs_count == '1) |=> (ovs_count == '1));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ovs_count == $past(ovs_count)) || (ovs_count == $past(ovs_count) + CNT_W'(1)));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    frm_valid |-> ##2 dec_valid);

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |-> ##2 !dec_valid);

endmodule

bind rx_accept_filter rxf_checker #(
  .LEN_W   (LEN_W),
  .CNT_W   (CNT_W),
  .MAX_STD (MAX_STD)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frm_valid   (frm_valid),
  .link_up     (link_up),
  .rx_en       (rx_en),
  .bus_master  (bus_master),
  .long_pkt_en (long_pkt_en),
  .store_bad   (store_bad),
  .frm_len     (frm_len),
  .dec_valid   (dec_valid),
  .dec_accept  (dec_accept),
  .ovs_count   (ovs_count)
);

// File: tb/tb_rx_accept_filter.sv
module tb_rx_accept_filter;

  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic        link_up, rx_en, bus_master, bcast_accept, mcast_promisc, ucast_promisc;
  logic        vlan_filter_en, long_pkt_en, store_bad;
  logic [1:0]  hash_offset;
  logic [15:0] vlan_type;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [6:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        frm_valid;
  logic [47:0] frm_dst;
  logic [15:0] frm_etype, frm_tci;
  logic [14:0] frm_len;
  logic        dec_valid, dec_accept;
  logic [CW-1:0] ovs_count;

  rx_accept_filter #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .link_up(link_up), .rx_en(rx_en), .bus_master(bus_master),
    .bcast_accept(bcast_accept), .mcast_promisc(mcast_promisc), .ucast_promisc(ucast_promisc),
    .vlan_filter_en(vlan_filter_en), .long_pkt_en(long_pkt_en), .store_bad(store_bad),
    .hash_offset(hash_offset), .vlan_type(vlan_type), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_dst(frm_dst),
    .frm_etype(frm_etype), .frm_tci(frm_tci), .frm_len(frm_len), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .ovs_count(ovs_count)
  );

  // ctrl = {link, rx_en, bus_master, bcast, mcast_p, ucast_p, vlan_f, long, store_bad}
  localparam logic [8:0] RDY = 9'b111_000_000;
  localparam logic [8:0] BAM = 9'b000_100_000;
  localparam logic [8:0] MPE = 9'b000_010_000;
  localparam logic [8:0] UPE = 9'b000_001_000;
  localparam logic [8:0] VFE = 9'b000_000_100;
  localparam logic [8:0] LPE = 9'b000_000_010;
  localparam logic [8:0] SBP = 9'b000_000_001;

  localparam logic [47:0] A_S3   = 48'h5544_3322_1102;  // valid slot 3
  localparam logic [47:0] A_S5   = 48'hEEDD_CCBB_AA02;  // slot 5, not valid
  localparam logic [47:0] A_BC   = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] A_MC   = 48'h0100_005E_0001;
  localparam logic [47:0] A_UC   = 48'h0605_0403_0A02;
  localparam logic [47:0] A_HASH = 48'h3412_005E_0001;

  typedef struct packed {
    logic [8:0]  ctrl;
    logic [1:0]  hoff;
    logic [47:0] dst;
    logic [15:0] etype;
    logic [15:0] tci;
    logic [14:0] len;
    logic        exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{9'b011_000_000, 2'd0, A_S3, 16'h0800, 16'h0, 15'd64, 1'b0, 8'd1},   // R1 link down
    '{9'b101_000_000, 2'd0, A_S3, 16'h0800, 16'h0, 15'd64, 1'b0, 8'd1},   // R1 rx off
    '{9'b110_000_000, 2'd0, A_S3, 16'h0800, 16'h0, 15'd64, 1'b0, 8'd1},   // R1 no mastering
    '{RDY,            2'd0, A_S3, 16'h0800, 16'h0, 15'd64, 1'b1, 8'd5},   // R5 slot hit
    '{RDY,            2'd0, A_S5, 16'h0800, 16'h0, 15'd64, 1'b0, 8'd5},   // R5 invalid slot
    '{RDY|BAM,        2'd0, A_BC, 16'h0800, 16'h0, 15'd64, 1'b1, 8'd2},   // R2
    '{RDY|MPE,        2'd0, A_BC, 16'h0800, 16'h0, 15'd64, 1'b0, 8'd2},   // R2 bcast not via mcast
    '{RDY|MPE,        2'd0, A_MC, 16'h0800, 16'h0, 15'd64, 1'b1, 8'd3},   // R3
    '{RDY,            2'd0, A_MC, 16'h0800, 16'h0, 15'd64, 1'b0, 8'd3},   // R3 off
    '{RDY|UPE,        2'd0, A_UC, 16'h0800, 16'h0, 15'd64, 1'b1, 8'd4},   // R4
    '{RDY,            2'd0, A_UC, 16'h0800, 16'h0, 15'd64, 1'b0, 8'd4},   // R4 off
    '{RDY|UPE,        2'd0, A_MC, 16'h0800, 16'h0, 15'd64, 1'b0, 8'd4},   // R4 not for mcast
    '{RDY,            2'd0, A_HASH, 16'h0800, 16'h0, 15'd64, 1'b1, 8'd6}, // R6 shift 4
    '{RDY,            2'd1, A_HASH, 16'h0800, 16'h0, 15'd64, 1'b1, 8'd6}, // R6 shift 3
    '{RDY,            2'd3, A_HASH, 16'h0800, 16'h0, 15'd64, 1'b0, 8'd6}, // R6 shift 0
    '{RDY|VFE,        2'd0, A_S3, 16'h8100, 16'h2064, 15'd64, 1'b1, 8'd7}, // R7 vid 100
    '{RDY|VFE,        2'd0, A_S3, 16'h8100, 16'h2065, 15'd64, 1'b0, 8'd7}, // R7 vid 101
    '{RDY,            2'd0, A_S3, 16'h8100, 16'h2065, 15'd64, 1'b1, 8'd7}, // R7 filter off
    '{RDY|VFE,        2'd0, A_S3, 16'h0800, 16'h0065, 15'd64, 1'b1, 8'd7}, // R7 untagged
    '{RDY,            2'd0, A_S3, 16'h0800, 16'h0, 15'd1518, 1'b1, 8'd8},  // R8
    '{RDY,            2'd0, A_S3, 16'h0800, 16'h0, 15'd1519, 1'b0, 8'd8},  // R8 counts
    '{RDY|LPE,        2'd0, A_S3, 16'h0800, 16'h0, 15'd1519, 1'b1, 8'd8},  // R8
    '{RDY|LPE,        2'd0, A_S3, 16'h0800, 16'h0, 15'd16380, 1'b1, 8'd8}, // R8
    '{RDY|LPE,        2'd0, A_S3, 16'h0800, 16'h0, 15'd16381, 1'b0, 8'd8}, // R8 counts
    '{RDY|SBP,        2'd0, A_S3, 16'h0800, 16'h0, 15'd16381, 1'b1, 8'd9}, // R9
    '{RDY|SBP,        2'd0, A_UC, 16'h0800, 16'h0, 15'd2000, 1'b0, 8'd9}   // R9 still filtered
  };

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_frame(input vec_t v);
    {link_up, rx_en, bus_master, bcast_accept, mcast_promisc, ucast_promisc,
     vlan_filter_en, long_pkt_en, store_bad} = v.ctrl;
    hash_offset = v.hoff;
    frm_dst     = v.dst;
    frm_etype   = v.etype;
    frm_tci     = v.tci;
    frm_len     = v.len;
    frm_valid   = 1'b1;
  endtask

  task automatic apply(input vec_t v, input int idx);
    @(negedge clk);
    drive_frame(v);
    @(negedge clk);
    frm_valid = 1'b0;
    @(negedge clk);
    check({dec_valid, dec_accept} === {1'b1, v.exp}, $sformatf("R%0d", v.req),
          $sformatf("vector %0d {valid,accept}", idx),
          {dec_valid, dec_accept}, {1'b1, v.exp});
  endtask

  task automatic wr(input logic [1:0] sel, input logic [6:0] addr, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  vec_t v;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    {link_up, rx_en, bus_master, bcast_accept, mcast_promisc, ucast_promisc,
     vlan_filter_en, long_pkt_en, store_bad} = '0;
    hash_offset = 2'd0; vlan_type = 16'h8100;
    cfg_we = 1'b0; cfg_sel = 2'd0; cfg_addr = '0; cfg_wdata = '0;
    frm_valid = 1'b0; frm_dst = '0; frm_etype = '0; frm_tci = '0; frm_len = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R13 reset state
    @(negedge clk);
    check(dec_valid === 1'b0, "R13", "dec_valid after reset", dec_valid, 0);
    check(ovs_count === '0, "R13", "ovs_count after reset", ovs_count, 0);

    for (int w = 0; w < 128; w++) begin
      wr(2'd0, 7'(w), 32'h0);
      wr(2'd1, 7'(w), 32'h0);
    end
    // R13 slots invalid after reset: exact address of slot 3 is not matched yet
    v = '{RDY, 2'd0, A_S3, 16'h0800, 16'h0, 15'd64, 1'b0, 8'd13};
    apply(v, 100);

    // program tables (R5 slot packing, R6 hash words, R7 VLAN word)
    wr(2'd2, 7'd3, 32'h3322_1102);
    wr(2'd3, 7'd3, 32'h8000_5544);
    wr(2'd2, 7'd5, 32'hCCBB_AA02);
    wr(2'd3, 7'd5, 32'h0000_EEDD);
    wr(2'd0, 7'd26, 32'h0000_0002);
    wr(2'd0, 7'd52, 32'h0000_0004);
    wr(2'd1, 7'd3,  32'h0000_0010);

    for (int i = 0; i < NV; i++) apply(VECS[i], i);

    // R10: two counted oversize frames so far
    @(negedge clk);
    check(ovs_count === CW'(2), "R10", "ovs_count after table", ovs_count, 2);

    // R1: not-ready oversize frame is not counted
    v = '{9'b011_000_000, 2'd0, A_S3, 16'h0800, 16'h0, 15'd3000, 1'b0, 8'd1};
    apply(v, 101);
    check(ovs_count === CW'(2), "R1", "ovs_count after not-ready oversize", ovs_count, 2);

    // R11: back-to-back frames, accept then reject, then idle
    @(negedge clk);
    drive_frame('{RDY, 2'd0, A_S3, 16'h0800, 16'h0, 15'd64, 1'b1, 8'd11});
    @(negedge clk);
    drive_frame('{RDY, 2'd0, A_S5, 16'h0800, 16'h0, 15'd64, 1'b0, 8'd11});
    @(negedge clk);
    frm_valid = 1'b0;
    check({dec_valid, dec_accept} === 2'b11, "R11", "first pulse", {dec_valid, dec_accept}, 3);
    @(negedge clk);
    check({dec_valid, dec_accept} === 2'b10, "R11", "second pulse", {dec_valid, dec_accept}, 2);
    @(negedge clk);
    check(dec_valid === 1'b0, "R11", "idle after burst", dec_valid, 0);

    // R12: VLAN write in the same cycle as the frame does not apply to it
    @(negedge clk);
    drive_frame('{RDY|VFE, 2'd0, A_S3, 16'h8100, 16'h2065, 15'd64, 1'b0, 8'd12});
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_addr = 7'd3; cfg_wdata = 32'h0000_0030;
    @(negedge clk);
    frm_valid = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    check({dec_valid, dec_accept} === 2'b10, "R12", "same-cycle write frame",
          {dec_valid, dec_accept}, 2);
    v = '{RDY|VFE, 2'd0, A_S3, 16'h8100, 16'h2065, 15'd64, 1'b1, 8'd12};
    apply(v, 102);

    // R10 saturation: 13 more counted frames reach all ones, then hold
    v = '{RDY, 2'd0, A_S3, 16'h0800, 16'h0, 15'd2000, 1'b0, 8'd10};
    for (int k = 0; k < 13; k++) apply(v, 200 + k);
    check(ovs_count === CW'(15), "R10", "ovs_count at limit", ovs_count, 15);
    apply(v, 300);
    apply(v, 301);
    check(ovs_count === CW'(15), "R10", "ovs_count saturated", ovs_count, 15);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule